// File: doc/BRIEF.md
# Synchronous Pipelined Burst SRAM

This block is a synthesizable behavioural model of a single-clock static RAM with a four-beat burst engine. A word is split into four byte lanes. Every input is registered on the rising clock edge: address, write data, strobes, write controls, chip selects and order select. The array access happens on the next edge, and read data passes through a registered output stage. A read therefore shows up two edges after its address was captured.

An access begins on either of two active-low address strobes, and only while all three active-low chip selects are low. The processor strobe always starts a read. The controller strobe starts a write if any lane is selected for writing, and a read otherwise. Later beats reuse the captured starting address. A 2-bit beat counter replaces its low two bits, and that counter steps only on cycles where the advance input is low. The order input picks how the counter is combined with the start bits. Write data travels with each beat. The output-enable input decides only whether the pipelined read data is driven out.

Top module: `burst_sram`

## Requirements
- R1: A read whose address is sampled at clock edge E presents its word on `rdata_o`, with `rdata_drive_o` high, between edge E+2 and edge E+3. Before edge E+2 its data is not presented.
- R2: When `lane_wr_en_n` is low and `global_wr_n` is high, every lane n with `lane_wr_n[n]` low is written and the other lanes keep their contents. Lane n is bits [9n+8:9n]. When `lane_wr_en_n` is high, `lane_wr_n` has no effect.
- R3: When `global_wr_n` is low, all four lanes are written, whatever the values of `lane_wr_n` and `lane_wr_en_n`.
- R4: A cycle started by `proc_strobe_n` low is always a read and writes nothing, even if write controls are active. It also wins when `ctrl_strobe_n` is low in the same cycle.
- R5: A cycle started by `ctrl_strobe_n` alone writes if any lane is selected for writing, and drives no read data for that cycle. Otherwise it is a read.
- R6: On a cycle with no strobe that continues a burst, the beat counter steps by one when `advance_n` is low and holds when it is high. Each such cycle accesses the current beat address.
- R7: With `interleave_i` low, the beat address is the start address with its low two bits replaced by (start low bits + counter) mod 4. For example, start 9 gives 9, 10, 11, 8.
- R8: With `interleave_i` high, the low two bits are (start low bits XOR counter). For example, start 9 gives 9, 8, 11, 10. The upper address bits stay fixed for the whole burst.
- R9: A strobe sampled while any bit of `chip_sel_n` is high performs no access and ends the burst. Later strobe-free cycles perform no access until a new burst starts.
- R10: `rdata_drive_o` is high only while `out_en_n` is low. While it is low, `rdata_o` reads zero.
- R11: After a synchronous reset, there is no active burst and `rdata_drive_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address, sampled with a strobe |
| proc_strobe_n | input | 1 | Processor address strobe, active low; starts a read burst |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low; starts a read or write burst |
| advance_n | input | 1 | Beat counter step, active low |
| chip_sel_n | input | 3 | Three chip selects, all must be low to start |
| global_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_en_n | input | 1 | Enables the per-lane write inputs, active low |
| lane_wr_n | input | 4 | Per-lane write select, active low |
| interleave_i | input | 1 | Beat order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Output enable, active low |
| wdata_i | input | 4*LANE_W | Write data for the current beat |
| rdata_o | output | 4*LANE_W | Pipelined read data, zero when not driven |
| rdata_drive_o | output | 1 | High when rdata_o carries driven read data |

## Verification
The bench builds the block with ADDR_W=6 and LANE_W=9. This gives a 64-word array that the bench can fill completely with global-write bursts, so every later read has a known value. A compact address space also keeps burst wrap inside each four-word group, under both orders, easy to check against hand-computed address lists. A behavioural model compares both outputs on every cycle. Directed reads confirm the exact edge where data appears, the lane masks, strobe priority, deselection and output gating.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int LANES   = 4;
    localparam int BURST_W = 2;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic             pstb;
        logic             cstb;
        logic             adv;
        logic             sel_ok;
        logic             gw;
        logic             lane_en;
        logic [LANES-1:0] lane_sel;
        order_e           order;
    } req_s;

    function automatic logic [BURST_W-1:0] beat_offset(
        input order_e             order,
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] cnt
    );
        if (order == ORDER_INTERLEAVE) begin
            return start ^ cnt;
        end
        return start + cnt;
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input req_s r);
        if (r.gw) begin
            return '1;
        end
        if (r.lane_en) begin
            return r.lane_sel;
        end
        return '0;
    endfunction

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic                      proc_strobe_n,
    input  logic                      ctrl_strobe_n,
    input  logic                      advance_n,
    input  logic [2:0]                chip_sel_n,
    input  logic                      global_wr_n,
    input  logic                      lane_wr_en_n,
    input  logic [LANES-1:0]          lane_wr_n,
    input  logic                      interleave_i,
    input  logic [LANES*LANE_W-1:0]   wdata_i,
    output logic                      acc_rd_o,
    output logic [LANES-1:0]          acc_lanes_o,
    output logic [ADDR_W-1:0]         acc_addr_o,
    output logic [LANES*LANE_W-1:0]   acc_wdata_o
);

    localparam int DATA_W = LANES * LANE_W;

    req_s                in_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;

    logic                active_q;
    logic [ADDR_W-1:0]   base_q;
    logic [BURST_W-1:0]  cnt_q;

    logic                strobe;
    logic                start;
    logic [LANES-1:0]    wr_lanes;
    logic [BURST_W-1:0]  nxt_cnt;

    // Input capture stage
    always_ff @(posedge clk) begin
        if (rst) begin
            in_q <= '0;
        end else begin
            in_q.pstb     <= ~proc_strobe_n;
            in_q.cstb     <= ~ctrl_strobe_n;
            in_q.adv      <= ~advance_n;
            in_q.sel_ok   <= ~(|chip_sel_n);
            in_q.gw       <= ~global_wr_n;
            in_q.lane_en  <= ~lane_wr_en_n;
            in_q.lane_sel <= ~lane_wr_n;
            in_q.order    <= order_e'(interleave_i);
        end
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
    end

    // Cycle decode and beat address generation
    always_comb begin
        strobe   = in_q.pstb | in_q.cstb;
        start    = strobe & in_q.sel_ok;
        wr_lanes = lane_mask(in_q);
        nxt_cnt  = in_q.adv ? cnt_q + 1'b1 : cnt_q;

        acc_rd_o    = 1'b0;
        acc_lanes_o = '0;
        acc_addr_o  = base_q;
        acc_wdata_o = wdata_q;

        if (start) begin
            acc_addr_o = addr_q;
            if (in_q.pstb) begin
                acc_rd_o = 1'b1;
            end else begin
                acc_lanes_o = wr_lanes;
                acc_rd_o    = (wr_lanes == '0);
            end
        end else if (!strobe && active_q) begin
            acc_addr_o  = {base_q[ADDR_W-1:BURST_W],
                           beat_offset(in_q.order, base_q[BURST_W-1:0], nxt_cnt)};
            acc_lanes_o = wr_lanes;
            acc_rd_o    = (wr_lanes == '0);
        end
    end

    // Burst state
    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            base_q   <= '0;
            cnt_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            base_q   <= addr_q;
            cnt_q    <= '0;
        end else if (strobe) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            cnt_q <= nxt_cnt;
        end
    end

    AST_PROC_READS: assert property (@(posedge clk) disable iff (rst)
        (in_q.pstb && in_q.sel_ok) |-> (acc_rd_o && acc_lanes_o == '0)); // R4

    AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (rst)
        (active_q && !in_q.pstb && !in_q.cstb && !in_q.adv) |=> $stable(cnt_q)); // R6

    AST_DESELECT_ENDS: assert property (@(posedge clk) disable iff (rst)
        ((in_q.pstb || in_q.cstb) && !in_q.sel_ok) |=> !active_q); // R9

    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !in_q.pstb && !in_q.cstb) |-> (!acc_rd_o && acc_lanes_o == '0)); // R9

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      acc_rd_i,
    input  logic [LANES-1:0]          acc_lanes_i,
    input  logic [ADDR_W-1:0]         acc_addr_i,
    input  logic [LANES*LANE_W-1:0]   acc_wdata_i,
    output logic [LANES*LANE_W-1:0]   rd_data_o,
    output logic                      rd_vld_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANES*LANE_W-1:0] rd_word;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] mem [DEPTH];

            always_ff @(posedge clk) begin
                if (acc_lanes_i[g]) begin
                    mem[acc_addr_i] <= acc_wdata_i[g*LANE_W +: LANE_W];
                end
            end

            assign rd_word[g*LANE_W +: LANE_W] = mem[acc_addr_i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld_o <= 1'b0;
        end else begin
            rd_vld_o <= acc_rd_i;
        end
        if (acc_rd_i) begin
            rd_data_o <= rd_word;
        end
    end

    AST_RD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        acc_rd_i |-> (acc_lanes_i == '0)); // R5

endmodule

// File: rtl/burst_sram_out.sv
module burst_sram_out
    import burst_sram_pkg::*;
#(
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [LANES*LANE_W-1:0]   rd_data_i,
    input  logic                      rd_vld_i,
    input  logic                      out_en_n,
    output logic [LANES*LANE_W-1:0]   rdata_o,
    output logic                      rdata_drive_o
);

    logic [LANES*LANE_W-1:0] out_q;
    logic                    out_vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld_q <= 1'b0;
        end else begin
            out_vld_q <= rd_vld_i;
        end
        out_q <= rd_data_i;
    end

    assign rdata_drive_o = out_vld_q & ~out_en_n;
    assign rdata_o       = rdata_drive_o ? out_q : '0;

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_vld_q |-> $past(rd_vld_i)); // R1

    AST_DRIVE_GATED: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> (!rdata_drive_o && rdata_o == '0)); // R10

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !out_vld_q); // R11

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic                      proc_strobe_n,
    input  logic                      ctrl_strobe_n,
    input  logic                      advance_n,
    input  logic [2:0]                chip_sel_n,
    input  logic                      global_wr_n,
    input  logic                      lane_wr_en_n,
    input  logic [3:0]                lane_wr_n,
    input  logic                      interleave_i,
    input  logic                      out_en_n,
    input  logic [4*LANE_W-1:0]       wdata_i,
    output logic [4*LANE_W-1:0]       rdata_o,
    output logic                      rdata_drive_o
);

    localparam int DATA_W = LANES * LANE_W;

    logic                acc_rd;
    logic [LANES-1:0]    acc_lanes;
    logic [ADDR_W-1:0]   acc_addr;
    logic [DATA_W-1:0]   acc_wdata;
    logic [DATA_W-1:0]   rd_data;
    logic                rd_vld;

    burst_sram_ctrl #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .addr_i        (addr_i),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .advance_n     (advance_n),
        .chip_sel_n    (chip_sel_n),
        .global_wr_n   (global_wr_n),
        .lane_wr_en_n  (lane_wr_en_n),
        .lane_wr_n     (lane_wr_n),
        .interleave_i  (interleave_i),
        .wdata_i       (wdata_i),
        .acc_rd_o      (acc_rd),
        .acc_lanes_o   (acc_lanes),
        .acc_addr_o    (acc_addr),
        .acc_wdata_o   (acc_wdata)
    );

    burst_sram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_array (
        .clk         (clk),
        .rst         (rst),
        .acc_rd_i    (acc_rd),
        .acc_lanes_i (acc_lanes),
        .acc_addr_i  (acc_addr),
        .acc_wdata_i (acc_wdata),
        .rd_data_o   (rd_data),
        .rd_vld_o    (rd_vld)
    );

    burst_sram_out #(.LANE_W(LANE_W)) u_out (
        .clk           (clk),
        .rst           (rst),
        .rd_data_i     (rd_data),
        .rd_vld_i      (rd_vld),
        .out_en_n      (out_en_n),
        .rdata_o       (rdata_o),
        .rdata_drive_o (rdata_drive_o)
    );

endmodule

// File: tb/burst_sram_bench.sv
module burst_sram_bench;

    localparam int AW = 6;
    localparam int LW = 9;
    localparam int DW = 4 * LW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic          proc_strobe_n = 1'b1;
    logic          ctrl_strobe_n = 1'b1;
    logic          advance_n = 1'b1;
    logic [2:0]    chip_sel_n = 3'b000;
    logic          global_wr_n = 1'b1;
    logic          lane_wr_en_n = 1'b1;
    logic [3:0]    lane_wr_n = 4'hF;
    logic          interleave_i = 1'b0;
    logic          out_en_n = 1'b0;
    logic [DW-1:0] wdata_i = '0;
    logic [DW-1:0] rdata_o;
    logic          rdata_drive_o;

    int checks = 0;
    int errors = 0;
    int edge_cnt = 0;

    always #2 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .LANE_W(LW)) u_burst_sram (
        .clk(clk), .rst(rst), .addr_i(addr_i),
        .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
        .advance_n(advance_n), .chip_sel_n(chip_sel_n),
        .global_wr_n(global_wr_n), .lane_wr_en_n(lane_wr_en_n),
        .lane_wr_n(lane_wr_n), .interleave_i(interleave_i),
        .out_en_n(out_en_n), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .rdata_drive_o(rdata_drive_o)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return {9'(a + 300), 9'(a + 200), 9'(a + 100), 9'(a)};
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [DW-1:0] ref_mem [64];
    bit            p_vld, p_ps, p_cs, p_adv, p_sel, p_int;
    logic [3:0]    p_lanes;
    int            p_addr;
    logic [DW-1:0] p_wd;
    bit            m_act;
    int            m_base, m_cnt;
    bit            r_vld, o_vld;
    logic [DW-1:0] r_dat, o_dat;

    always @(posedge clk) begin
        if (rst) begin
            p_vld = 0; m_act = 0; m_cnt = 0; r_vld = 0; o_vld = 0;
        end else begin
            int  a;
            bit  acc;
            bit  rd;
            logic [3:0] ln;
            o_vld = r_vld;
            o_dat = r_dat;
            r_vld = 0;
            acc = 0; rd = 0; ln = 4'h0; a = 0;
            if (p_vld) begin
                if ((p_ps || p_cs) && p_sel) begin
                    acc = 1; a = p_addr;
                    ln = p_ps ? 4'h0 : p_lanes;
                    m_act = 1; m_base = p_addr; m_cnt = 0;
                end else if (p_ps || p_cs) begin
                    m_act = 0;
                end else if (m_act) begin
                    int lo;
                    if (p_adv) m_cnt = (m_cnt + 1) % 4;
                    lo = p_int ? ((m_base % 4) ^ m_cnt) : ((m_base % 4) + m_cnt) % 4;
                    a = (m_base / 4) * 4 + lo;
                    acc = 1; ln = p_lanes;
                end
            end
            if (acc) begin
                rd = (ln == 4'h0);
                for (int k = 0; k < 4; k++)
                    if (ln[k]) ref_mem[a][k*LW +: LW] = p_wd[k*LW +: LW];
                if (rd) begin
                    r_vld = 1;
                    r_dat = ref_mem[a];
                end
            end
        end
        p_vld = !rst;
        p_ps  = !proc_strobe_n;
        p_cs  = !ctrl_strobe_n;
        p_adv = !advance_n;
        p_sel = (chip_sel_n == 3'b000);
        p_int = interleave_i;
        p_lanes = !global_wr_n ? 4'hF : (!lane_wr_en_n ? ~lane_wr_n : 4'h0);
        p_addr = int'(addr_i);
        p_wd = wdata_i;
    end

    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    // ---------------- directed expectations ----------------
    bit            exp_on   [8];
    int            exp_edge [8];
    logic [DW-1:0] exp_dq   [8];
    bit            exp_drv  [8];
    string         exp_tag  [8];

    task automatic want(input logic [DW-1:0] d, input bit drv, input string tag);
        int s;
        s = (edge_cnt + 3) % 8;
        exp_on[s] = 1; exp_edge[s] = edge_cnt + 3;
        exp_dq[s] = d; exp_drv[s] = drv; exp_tag[s] = tag;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            // R1: cycle-accurate comparison against the model
            check("R1 model data", rdata_o, (o_vld && !out_en_n) ? o_dat : '0);
            check("R1 model drive", DW'(rdata_drive_o), DW'(o_vld && !out_en_n));
            if (exp_on[edge_cnt % 8] && exp_edge[edge_cnt % 8] == edge_cnt) begin
                check(exp_tag[edge_cnt % 8], rdata_o, exp_dq[edge_cnt % 8]);
                check(exp_tag[edge_cnt % 8], DW'(rdata_drive_o),
                      DW'(exp_drv[edge_cnt % 8]));
                exp_on[edge_cnt % 8] = 0;
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle();
        proc_strobe_n = 1; ctrl_strobe_n = 1; advance_n = 1;
        chip_sel_n = 3'b000; global_wr_n = 1; lane_wr_en_n = 1;
        lane_wr_n = 4'hF; addr_i = '0; wdata_i = '0;
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
        idle();
    endtask

    task automatic gap();
        for (int i = 0; i < 4; i++) tick();
    endtask

    task automatic read_start(input int a, input bit inter, input string tag);
        proc_strobe_n = 0; addr_i = AW'(a); interleave_i = inter;
        want(pat(a), 1, tag);
        tick();
    endtask

    task automatic adv_read(input int a, input string tag);
        advance_n = 0;
        want(pat(a), 1, tag);
        tick();
    endtask

    initial begin
        logic [DW-1:0] e;
        for (int i = 0; i < 8; i++) exp_on[i] = 0;
        repeat (3) @(negedge clk);
        #1;
        rst = 0;
        // R11: nothing driven after reset
        check("R11 drive after reset", DW'(rdata_drive_o), '0);
        check("R11 data after reset", rdata_o, '0);

        // Fill the whole array with global-write bursts (R3, R7)
        for (int b = 0; b < 64; b += 4) begin
            for (int k = 0; k < 4; k++) begin
                if (k == 0) begin ctrl_strobe_n = 0; addr_i = AW'(b); end
                else advance_n = 0;
                global_wr_n = 0;
                wdata_i = pat(b + k);
                tick();
            end
        end
        gap();

        // R7: linear order from start 9 -> 9,10,11,8
        read_start(9, 0, "R7 beat0");
        adv_read(10, "R7 beat1");
        adv_read(11, "R7 beat2");
        adv_read(8, "R7 beat3");
        gap();

        // R8: interleaved order from start 9 -> 9,8,11,10
        interleave_i = 1;
        read_start(9, 1, "R8 beat0");
        interleave_i = 1; adv_read(8, "R8 beat1");
        interleave_i = 1; adv_read(11, "R8 beat2");
        interleave_i = 1; adv_read(10, "R8 beat3");
        interleave_i = 0;
        gap();

        // R6: hold without advance, then step
        read_start(12, 0, "R6 start");
        want(pat(12), 1, "R6 hold"); tick();
        adv_read(13, "R6 step");
        gap();

        // R4: processor strobe with write controls and the other strobe
        proc_strobe_n = 0; ctrl_strobe_n = 0; addr_i = AW'(20);
        global_wr_n = 0; wdata_i = '0;
        want(pat(20), 1, "R4 priority read");
        tick();
        gap();
        read_start(20, 0, "R4 no write happened");
        gap();

        // R5: controller strobe with no write controls is a read
        ctrl_strobe_n = 0; addr_i = AW'(21);
        want(pat(21), 1, "R5 ctrl read");
        tick();
        gap();

        // R2 / R5: lane write of lanes 0 and 2, no read data driven
        ctrl_strobe_n = 0; addr_i = AW'(30); lane_wr_en_n = 0;
        lane_wr_n = 4'b1010; wdata_i = {DW{1'b1}};
        want('0, 0, "R5 write drives nothing");
        tick();
        gap();
        e = pat(30); e[8:0] = 9'h1FF; e[26:18] = 9'h1FF;
        proc_strobe_n = 0; addr_i = AW'(30);
        want(e, 1, "R2 lane mask");
        tick();
        gap();
        // R2: lane selects ignored while the lane enable is high
        ctrl_strobe_n = 0; addr_i = AW'(31); lane_wr_n = 4'h0; wdata_i = '0;
        want(pat(31), 1, "R2 lanes ignored");
        tick();
        gap();

        // R3: global write overrides lane selects
        ctrl_strobe_n = 0; addr_i = AW'(33); global_wr_n = 0; lane_wr_en_n = 0;
        lane_wr_n = 4'b1110; wdata_i = 36'h0_1234_5678;
        tick();
        gap();
        proc_strobe_n = 0; addr_i = AW'(33);
        want(36'h0_1234_5678, 1, "R3 global write");
        tick();
        gap();

        // R9: deselected strobe, then advance cycle, no access
        ctrl_strobe_n = 0; addr_i = AW'(40); chip_sel_n = 3'b010;
        global_wr_n = 0; wdata_i = '0;
        want('0, 0, "R9 deselected");
        tick();
        advance_n = 0; global_wr_n = 0; wdata_i = '0;
        want('0, 0, "R9 no burst after deselect");
        tick();
        gap();
        read_start(40, 0, "R9 location untouched");
        gap();

        // R10: output enable high suppresses driving
        out_en_n = 1;
        proc_strobe_n = 0; addr_i = AW'(41);
        want('0, 0, "R10 gated");
        tick();
        gap();
        out_en_n = 0;
        read_start(41, 0, "R10 driven");
        gap();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule